// File: doc/BRIEF.md
# Byte-Lane Static Memory with Dual Select

This block is a clocked behavioural model of a word-wide static memory with two independently gated 8-bit lanes. On every rising clock edge it samples an address, a pair of selects of opposite polarity, an active-low output enable, an active-low write enable and one active-low enable per byte lane. From these it decides whether the cycle is a store, a fetch, an output-disabled cycle or standby.

A store updates only the lanes whose enable is low. A fetch returns the addressed word one clock later, together with a per-lane drive vector that stands in for three-state data pins. A lane that is not driven always presents zero on its read-data bits.

The depth is set by `ADDR_W`; `ADDR_W = 16` gives the full 65,536-word array. The default is a smaller 1,024-word array so that elaboration stays light. Stored contents are never cleared by reset. The reset input is asserted asynchronously, and its release is synchronised inside the block before it reaches the output registers.

Top module: `sram_byte_lane`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits. A word stored at an address is returned by a later fetch of that address, and other addresses keep their own contents.
- R2: Standby applies when `sel_n` is high, when `sel` is low, or when both `lane_en_n` bits are high. In standby, `lane_drive` is 2'b00 one clock later and no stored bit changes.
- R3: A fetch (selected, `wr_en_n` high, `out_en_n` low) sets `lane_drive[0]` one clock later if `lane_en_n[0]` is low, and `lane_drive[1]` if `lane_en_n[1]` is low. Each driven lane presents the stored byte: lane 0 on bits 7:0 and lane 1 on bits 15:8.
- R4: A selected cycle with `wr_en_n` high and `out_en_n` high drives no lane one clock later.
- R5: A store (selected, `wr_en_n` low, at least one lane enable low) writes `wr_data` only into the lanes whose enable is low, whatever the level of `out_en_n`. The other lane keeps its old byte.
- R6: The clock after a store, `lane_drive` is 2'b00.
- R7: Whenever a lane is not driven, its 8 bits of `rd_data` are zero.
- R8: While reset is asserted, and until the synchronised release, `lane_drive` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Active-low select |
| sel | input | 1 | Active-high select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| lane_en_n | input | 2 | Active-low lane enables; bit 0 is the low byte |
| wr_data | input | 16 | Store data |
| rd_data | output | 16 | Fetched data, zero in undriven lanes |
| lane_drive | output | 2 | Per-lane drive indication |

## Verification
Every control decision is due exactly one rising edge after the inputs are sampled: a store changes the array at that edge, and a fetch shows its drive bits and data immediately after the same edge. The bench applies each stimulus at a falling edge, lets the reference model update at the next rising edge, and compares both outputs at the falling edge that follows. A check therefore always looks at the result of the stimulus just applied. After reset is released, the bench waits out the two-stage release synchroniser before the first functional cycle.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_FETCH = 2'd2,
    MODE_STORE = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_n,
  input  logic             sel,
  input  logic             out_en_n,
  input  logic             wr_en_n,
  input  logic [LANES-1:0] lane_en_n,
  output sram_mode_e       mode
);
  logic chosen;

  always_comb begin
    // Selected only with both selects active and some lane enabled.
    chosen = !sel_n && sel && !(&lane_en_n);
    if (!chosen)       mode = MODE_IDLE;
    else if (!wr_en_n) mode = MODE_STORE;
    else if (!out_en_n) mode = MODE_FETCH;
    else               mode = MODE_HOLD;
  end
endmodule

// File: rtl/sram_lane.sv
module sram_lane
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_mode_e        mode,
  input  logic              lane_on,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wr_byte,
  output logic [LANE_W-1:0] rd_byte,
  output logic              drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] cells [DEPTH];
  logic              store_hit;
  logic              fetch_hit;
  logic              drive_d;
  logic [LANE_W-1:0] rd_d;

  always_comb begin
    store_hit = (mode == MODE_STORE) && lane_on;
    fetch_hit = (mode == MODE_FETCH) && lane_on;
    drive_d   = fetch_hit;
    rd_d      = fetch_hit ? cells[addr] : '0;
  end

  // Array: no reset, written only on a store hit.
  always_ff @(posedge clk) begin
    if (store_hit) cells[addr] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive   <= 1'b0;
      rd_byte <= '0;
    end else begin
      drive   <= drive_d;
      rd_byte <= rd_d;
    end
  end
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_n,
  input  logic                    sel,
  input  logic                    out_en_n,
  input  logic                    wr_en_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic [LANES-1:0]        lane_drive
);
  logic       core_rst_n;
  sram_mode_e mode;

  sram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  sram_mode_dec #(.LANES(LANES)) u_dec (
    .sel_n     (sel_n),
    .sel       (sel),
    .out_en_n  (out_en_n),
    .wr_en_n   (wr_en_n),
    .lane_en_n (lane_en_n),
    .mode      (mode)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .mode    (mode),
      .lane_on (!lane_en_n[g]),
      .addr    (addr),
      .wr_byte (wr_data[g*LANE_W +: LANE_W]),
      .rd_byte (rd_data[g*LANE_W +: LANE_W]),
      .drive   (lane_drive[g])
    );
  end
endmodule

// File: rtl/sram_byte_lane_chk.sv
module sram_byte_lane_chk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    core_rst_n,
  input logic                    sel_n,
  input logic                    sel,
  input logic                    out_en_n,
  input logic                    wr_en_n,
  input logic [LANES-1:0]        lane_en_n,
  input logic [LANES*LANE_W-1:0] rd_data,
  input logic [LANES-1:0]        lane_drive
);
  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (sel_n || !sel || (&lane_en_n)) |=> (lane_drive == '0));

  p_outdis_quiet_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!sel_n && sel && wr_en_n && out_en_n) |=> (lane_drive == '0));

  p_store_quiet_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!sel_n && sel && !wr_en_n) |=> (lane_drive == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_fetch_drive_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
      (!sel_n && sel && wr_en_n && !out_en_n && !lane_en_n[g]) |=> lane_drive[g]);

    p_lane_off_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
      lane_en_n[g] |=> !lane_drive[g]);

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
      !lane_drive[g] |-> (rd_data[g*LANE_W +: LANE_W] == '0));
  end
endmodule

bind sram_byte_lane sram_byte_lane_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .sel_n      (sel_n),
  .sel        (sel),
  .out_en_n   (out_en_n),
  .wr_en_n    (wr_en_n),
  .lane_en_n  (lane_en_n),
  .rd_data    (rd_data),
  .lane_drive (lane_drive)
);

// File: tb/sram_byte_lane_test.sv
module sram_byte_lane_test;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              sel_n, sel, out_en_n, wr_en_n;
  logic [1:0]        lane_en_n;
  logic [15:0]       wr_data;
  logic [15:0]       rd_data;
  logic [1:0]        lane_drive;

  int checks   = 0;
  int failures = 0;
  logic [15:0] model [DEPTH];
  logic [15:0] exp_data;
  logic [1:0]  exp_drv;

  sram_byte_lane #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel(sel),
    .out_en_n(out_en_n), .wr_en_n(wr_en_n), .lane_en_n(lane_en_n),
    .wr_data(wr_data), .rd_data(rd_data), .lane_drive(lane_drive)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply at a falling edge, model at the rising edge, compare at the next falling edge.
  task automatic step(input int a, input logic sn, input logic s, input logic oen,
                      input logic wen, input logic [1:0] ben, input logic [15:0] wd,
                      input string tag);
    logic chosen;
    addr = a[ADDR_W-1:0]; sel_n = sn; sel = s; out_en_n = oen;
    wr_en_n = wen; lane_en_n = ben; wr_data = wd;
    @(posedge clk);
    chosen   = !sn && s && !(&ben);
    exp_drv  = 2'b00;
    exp_data = 16'h0000;
    if (chosen && !wen) begin
      if (!ben[0]) model[a][7:0]  = wd[7:0];
      if (!ben[1]) model[a][15:8] = wd[15:8];
    end else if (chosen && !oen) begin
      exp_drv = ~ben;
      if (!ben[0]) exp_data[7:0]  = model[a][7:0];
      if (!ben[1]) exp_data[15:8] = model[a][15:8];
    end
    @(negedge clk);
    check({tag, " drive"}, {14'd0, lane_drive}, {14'd0, exp_drv});
    check({tag, " data"}, rd_data, exp_data);
  endtask

  task automatic wr(input int a, input logic [1:0] ben, input logic oen,
                    input logic [15:0] wd, input string tag);
    step(a, 1'b0, 1'b1, oen, 1'b0, ben, wd, tag);
  endtask

  task automatic rd(input int a, input logic [1:0] ben, input string tag);
    step(a, 1'b0, 1'b1, 1'b0, 1'b1, ben, 16'hDEAD, tag);
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; sel_n = 1'b1; sel = 1'b0; out_en_n = 1'b1;
    wr_en_n = 1'b1; lane_en_n = 2'b11; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R8 reset drive", {14'd0, lane_drive}, 16'h0000);
    check("R8 reset data", rd_data, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 post-release drive", {14'd0, lane_drive}, 16'h0000);

    // R1 / R5: full words, output enable at both levels during store
    wr(0, 2'b00, 1'b1, 16'h1234, "R5 store a0");
    wr(DEPTH-1, 2'b00, 1'b0, 16'hA55A, "R6 store top oe low");
    wr(5, 2'b00, 1'b1, 16'hBEEF, "R6 store a5");
    rd(0, 2'b00, "R1 R3 fetch a0");
    rd(DEPTH-1, 2'b00, "R1 R3 fetch top");
    rd(5, 2'b00, "R1 R3 fetch a5");
    // R5 single lanes
    wr(5, 2'b10, 1'b1, 16'h77C3, "R5 low lane only");
    rd(5, 2'b00, "R5 after low-lane store");
    wr(5, 2'b01, 1'b0, 16'h9911, "R5 high lane only");
    rd(5, 2'b00, "R5 after high-lane store");
    // R3 / R7 lane combinations
    rd(DEPTH-1, 2'b10, "R3 R7 low lane fetch");
    rd(DEPTH-1, 2'b01, "R3 R7 high lane fetch");
    // R4 output disabled
    step(0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 16'h0, "R4 output disabled");
    // R2 standby by each condition, with store attempts
    step(0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 16'hFFFF, "R2 sel_n high");
    step(0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 16'hFFFF, "R2 sel low");
    step(0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 16'hFFFF, "R2 both lanes off");
    step(0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 16'hFFFF, "R2 fetch lanes off");
    rd(0, 2'b00, "R2 contents kept");
    // R1 address sweep
    for (int i = 16; i < 48; i++) wr(i * 7, 2'b00, i[0], 16'(i * 16'h0101 + 3), "R1 sweep store");
    for (int i = 16; i < 48; i++) rd(i * 7, 2'(i % 3), "R1 R3 sweep fetch");
    // R6 store directly after fetch, then fetch
    rd(5, 2'b00, "R3 before store");
    wr(5, 2'b00, 1'b0, 16'h0F0F, "R6 store after fetch");
    rd(5, 2'b00, "R1 fetch new word");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule